// File: doc/BRIEF.md
# Rotate Unit With Carry And Overflow Flags

This block is a purely combinational rotate datapath for an integer execution pipe. It takes one operand of 8, 16 or 32 bits and a raw shift count. It performs one of four rotations: plain left, plain right, left through the carry flag, or right through the carry flag. It returns the rotated value, the new carry and overflow flags, and a strobe that says whether the flag register should be written. The issuing stage supplies the operand, the size code, the count, the operation code and the current carry and overflow bits. It writes the outputs back in the same cycle.

The block reduces the count internally in two steps. First it keeps only the five low count bits. It then reduces that value modulo the operand width for plain rotates, or modulo the width plus one for carry rotates. When the masked count is zero, the block changes nothing. The remaining status flags (sign, zero, auxiliary carry, parity) enter on one bus and leave on the output bus unmodified, so the block can sit in the flag path without special cases.

Top module: `rot_unit`

## Requirements
- R1: Only bits 4:0 of `count_raw` are used. A raw count of 32 acts as 0, and 33 acts as 1.
- R2: For carry rotates (`op_sel` 2'b10 or 2'b11), the step count is the masked count mod 9 for byte operands and mod 17 for halfword operands. For word operands it is the masked count unreduced.
- R3: For plain rotates (`op_sel` 2'b00 left, 2'b01 right), the step count is the masked count mod 8, mod 16 or mod 32 according to the operand size. Each step moves the bit leaving one end into the other end.
- R4: `op_sel` 2'b10 (left through carry): on each step `cf_in` (or the running carry) enters bit 0, and the bit leaving the top becomes the new carry.
- R5: `op_sel` 2'b11 (right through carry): on each step the running carry enters the top bit of the operand, and bit 0 becomes the new carry.
- R6: After a plain left rotate, `cf_out` equals bit 0 of the result. After a plain right rotate, it equals the top bit of the operand-sized result.
- R7: When `flag_we` is 1, `of_out` is `cf_out` XOR the result's top bit for left rotates. For right rotates it is the XOR of the result's two top bits. The same rule applies to every nonzero count.
- R8: When the masked count is zero, `result` equals the operand zero-extended from its size, `cf_out` equals `cf_in`, and `of_out` equals `of_in`.
- R9: When the masked count is nonzero but reduces to zero, the data is unchanged. For plain rotates the carry still follows the end-bit rule of R6. For carry rotates the carry stays `cf_in`.
- R10: `flag_we` is 1 exactly when the masked count is nonzero.
- R11: `stat_out` always equals `stat_in`. The four other status flags are never altered.
- R12: `size_sel` 2'b00 selects 8 bits, 2'b01 selects 16 bits, and 2'b10 or 2'b11 selects 32 bits. Result bits above the selected size are 0, and operand bits above it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 32 | Value to rotate; low bits used per size |
| size_sel | input | 2 | Operand size code |
| count_raw | input | 8 | Raw rotate count before masking |
| op_sel | input | 2 | Rotation kind: bit 1 = through carry, bit 0 = right |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| stat_in | input | 4 | Other status flags, passed through |
| result | output | 32 | Rotated value, zero above the operand size |
| cf_out | output | 1 | New carry flag |
| of_out | output | 1 | New overflow flag |
| flag_we | output | 1 | Carry/overflow write enable |
| stat_out | output | 4 | Unmodified status flags |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath and an 8-bit raw count. This means the raw counts 32 to 255 are reachable, which exercises the masking rule. All three operand sizes share one instance, so the byte and halfword lanes are driven with garbage in the upper operand bits. The directed cases hit each modulo boundary (9, 17, 8, 16, 31, 32, 33), and random counts cover the rest of the range for every size and operation.

// File: rtl/rot_pkg.sv
package rot_pkg;

    localparam int DATA_W     = 32;
    localparam int RAW_CNT_W  = 8;
    localparam int MCNT_W     = 5;
    localparam int STAT_W     = 4;
    localparam int N_LANES    = 3;
    localparam int LANE_SEL_W = $clog2(N_LANES);

    typedef enum logic [1:0] {
        OP_ROL = 2'b00,
        OP_ROR = 2'b01,
        OP_RCL = 2'b10,
        OP_RCR = 2'b11
    } rot_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } rot_size_e;

    typedef struct packed {
        logic msb;
        logic msb_m1;
        logic lsb;
    } rot_edge_t;

    function automatic int lane_width(input int idx);
        return 8 << idx;
    endfunction

    function automatic logic [LANE_SEL_W-1:0] lane_of(input rot_size_e sz);
        case (sz)
            SZ_BYTE: return LANE_SEL_W'(0);
            SZ_HALF: return LANE_SEL_W'(1);
            default: return LANE_SEL_W'(2);
        endcase
    endfunction

    function automatic logic goes_right(input rot_op_e op);
        return op[0];
    endfunction

    function automatic logic thru_carry(input rot_op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/rot_count.sv
module rot_count
    import rot_pkg::*;
#(
    parameter int RAW_W = RAW_CNT_W
) (
    input  logic [RAW_W-1:0]  count_raw,
    output logic [MCNT_W-1:0] mcnt,
    output logic              active
);

    logic [RAW_W-1:0] unused_hi;

    always_comb begin
        mcnt      = count_raw[MCNT_W-1:0];
        active    = |count_raw[MCNT_W-1:0];
        unused_hi = count_raw;
    end

endmodule

// File: rtl/rot_lane.sv
module rot_lane
    import rot_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      data,
    input  logic              cf_in,
    input  rot_op_e           op,
    input  logic [MCNT_W-1:0] mcnt,
    output logic [W-1:0]      res,
    output logic              cf
);

    localparam int VW  = W + 1;
    localparam int SHW = MCNT_W + 1;

    logic [SHW-1:0]    plain_n;
    logic [SHW-1:0]    thru_n;
    logic [2*W-1:0]    pd, pl_sh, pr_sh;
    logic [2*VW-1:0]   vd, vl_sh, vr_sh;
    logic [W-1:0]      rol_r, ror_r;
    logic [VW-1:0]     rcl_v, rcr_v;

    always_comb begin
        plain_n = SHW'(32'(mcnt) % W);
        thru_n  = SHW'(32'(mcnt) % VW);
        pd      = {data, data};
        vd      = {cf_in, data, cf_in, data};
        pl_sh   = pd << plain_n;
        pr_sh   = pd >> plain_n;
        vl_sh   = vd << thru_n;
        vr_sh   = vd >> thru_n;
        rol_r   = pl_sh[2*W-1:W];
        ror_r   = pr_sh[W-1:0];
        rcl_v   = vl_sh[2*VW-1:VW];
        rcr_v   = vr_sh[VW-1:0];
        case (op)
            OP_ROL: begin res = rol_r;          cf = rol_r[0];   end
            OP_ROR: begin res = ror_r;          cf = ror_r[W-1]; end
            OP_RCL: begin res = rcl_v[W-1:0];   cf = rcl_v[W];   end
            default: begin res = rcr_v[W-1:0];  cf = rcr_v[W];   end
        endcase
    end

    // A rotation only permutes bits; the count of ones is invariant.
    always_comb begin
        if (!thru_carry(op)) begin
            a_r3_plain_ones_kept: assert ($countones(res) == $countones(data));
        end else begin
            a_r4_ring_ones_kept: assert ($countones({cf, res}) == $countones({cf_in, data}));
        end
    end

endmodule

// File: rtl/rot_flags.sv
module rot_flags
    import rot_pkg::*;
(
    input  rot_op_e   op,
    input  rot_edge_t edge_bits,
    input  logic      lane_cf,
    input  logic      active,
    input  logic      cf_in,
    input  logic      of_in,
    output logic      cf_out,
    output logic      of_out,
    output logic      flag_we
);

    logic of_calc;

    always_comb begin
        if (goes_right(op)) of_calc = edge_bits.msb ^ edge_bits.msb_m1;
        else                of_calc = lane_cf ^ edge_bits.msb;
        flag_we = active;
        cf_out  = active ? lane_cf : cf_in;
        of_out  = active ? of_calc : of_in;
    end

    // R6: plain rotates leave the carry equal to the end bit of the result
    always_comb begin
        if (active && op == OP_ROL) begin
            a_r6_rol_carry_lsb: assert (cf_out == edge_bits.lsb);
        end
        if (active && op == OP_ROR) begin
            a_r6_ror_carry_msb: assert (cf_out == edge_bits.msb);
        end
    end

endmodule

// File: rtl/rot_unit.sv
module rot_unit
    import rot_pkg::*;
(
    input  logic [DATA_W-1:0]    operand,
    input  logic [1:0]           size_sel,
    input  logic [RAW_CNT_W-1:0] count_raw,
    input  logic [1:0]           op_sel,
    input  logic                 cf_in,
    input  logic                 of_in,
    input  logic [STAT_W-1:0]    stat_in,
    output logic [DATA_W-1:0]    result,
    output logic                 cf_out,
    output logic                 of_out,
    output logic                 flag_we,
    output logic [STAT_W-1:0]    stat_out
);

    rot_op_e                 op;
    rot_size_e               sz;
    logic [MCNT_W-1:0]       mcnt;
    logic                    active;
    logic [DATA_W-1:0]       lane_res [N_LANES];
    logic [N_LANES-1:0]      lane_cf;
    logic [LANE_SEL_W-1:0]   sel;
    rot_edge_t               edge_bits;
    logic [DATA_W-1:0]       ext_op;

    assign op = rot_op_e'(op_sel);
    assign sz = rot_size_e'(size_sel);

    rot_count #(.RAW_W(RAW_CNT_W)) u_count (
        .count_raw (count_raw),
        .mcnt      (mcnt),
        .active    (active)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LW = lane_width(g);
        rot_lane #(.W(LW)) u_lane (
            .data  (operand[LW-1:0]),
            .cf_in (cf_in),
            .op    (op),
            .mcnt  (mcnt),
            .res   (lane_res[g][LW-1:0]),
            .cf    (lane_cf[g])
        );
        if (LW < DATA_W) begin : g_pad
            assign lane_res[g][DATA_W-1:LW] = '0;
        end
    end

    always_comb begin
        sel    = lane_of(sz);
        result = lane_res[sel];
        ext_op = operand;
        edge_bits.lsb = result[0];
        case (sel)
            LANE_SEL_W'(0): begin
                edge_bits.msb    = result[7];
                edge_bits.msb_m1 = result[6];
                ext_op           = {24'd0, operand[7:0]};
            end
            LANE_SEL_W'(1): begin
                edge_bits.msb    = result[15];
                edge_bits.msb_m1 = result[14];
                ext_op           = {16'd0, operand[15:0]};
            end
            default: begin
                edge_bits.msb    = result[DATA_W-1];
                edge_bits.msb_m1 = result[DATA_W-2];
            end
        endcase
    end

    rot_flags u_flags (
        .op        (op),
        .edge_bits (edge_bits),
        .lane_cf   (lane_cf[sel]),
        .active    (active),
        .cf_in     (cf_in),
        .of_in     (of_in),
        .cf_out    (cf_out),
        .of_out    (of_out),
        .flag_we   (flag_we)
    );

    assign stat_out = stat_in;

    always_comb begin
        a_r10_we_tracks_count: assert (flag_we == (count_raw[4:0] != 5'd0));
        if (!flag_we) begin
            a_r8_idle_holds: assert (result == ext_op && cf_out == cf_in && of_out == of_in);
        end
        if (size_sel == 2'b00) begin
            a_r12_byte_upper_clear: assert (result[DATA_W-1:8] == '0);
        end
        if (size_sel == 2'b01) begin
            a_r12_half_upper_clear: assert (result[DATA_W-1:16] == '0);
        end
    end

endmodule

// File: tb/rot_unit_tb.sv
module rot_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] operand = '0;
    logic [1:0]  size_sel = '0;
    logic [7:0]  count_raw = '0;
    logic [1:0]  op_sel = '0;
    logic        cf_in = 1'b0;
    logic        of_in = 1'b0;
    logic [3:0]  stat_in = '0;
    logic [31:0] result;
    logic        cf_out, of_out, flag_we;
    logic [3:0]  stat_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    rot_unit u_dut (
        .operand(operand), .size_sel(size_sel), .count_raw(count_raw),
        .op_sel(op_sel), .cf_in(cf_in), .of_in(of_in), .stat_in(stat_in),
        .result(result), .cf_out(cf_out), .of_out(of_out),
        .flag_we(flag_we), .stat_out(stat_out)
    );

    // Step-by-step reference: {result, cf, of, we, stat}
    function automatic logic [38:0] model(input logic [31:0] d, input logic [1:0] sz,
                                          input logic [7:0] cnt, input logic [1:0] op,
                                          input logic cfi, input logic ofi, input logic [3:0] st);
        int w, m, n;
        logic [31:0] r, mask;
        logic c, o, t, ins;
        w    = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        r    = d & mask;
        m    = int'(cnt) & 31;
        if (m == 0) return {r, cfi, ofi, 1'b0, st};
        if (op[1]) n = (w == 8) ? m % 9 : (w == 16) ? m % 17 : m;
        else       n = m % w;
        c = cfi;
        for (int k = 0; k < n; k++) begin
            if (!op[0]) begin
                t   = r[w-1];
                ins = op[1] ? c : t;
                r   = ((r << 1) | {31'd0, ins}) & mask;
            end else begin
                t   = r[0];
                ins = op[1] ? c : t;
                r   = (r >> 1) | (ins ? (32'd1 << (w - 1)) : 32'd0);
            end
            if (op[1]) c = t;
        end
        if (!op[1]) c = op[0] ? r[w-1] : r[0];
        o = op[0] ? (r[w-1] ^ r[w-2]) : (c ^ r[w-1]);
        return {r, c, o, 1'b1, st};
    endfunction

    task automatic run(input string tag, input logic [31:0] d, input logic [1:0] sz,
                       input logic [7:0] cnt, input logic [1:0] op,
                       input logic cfi, input logic ofi, input logic [3:0] st);
        logic [38:0] exp, act;
        @(posedge clk);
        operand = d; size_sel = sz; count_raw = cnt; op_sel = op;
        cf_in = cfi; of_in = ofi; stat_in = st;
        @(negedge clk);
        exp = model(d, sz, cnt, op, cfi, ofi, st);
        act = {result, cf_out, of_out, flag_we, stat_out};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: op=%0d sz=%0d cnt=%0d d=%h actual=%h expected=%h",
                     tag, op, sz, cnt, d, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        string tg;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-state style idle check: all inputs zero
        run("R8 idle zero", 32'h0, 2'b00, 8'd0, 2'b00, 1'b0, 1'b0, 4'h0);
        // masking
        run("R1 count32", 32'hDEAD_BEEF, 2'b10, 8'd32, 2'b10, 1'b1, 1'b0, 4'h5);
        run("R1 count33", 32'hDEAD_BEEF, 2'b10, 8'd33, 2'b10, 1'b1, 1'b0, 4'h5);
        run("R1 R10 count224", 32'h1234_5678, 2'b01, 8'd224, 2'b00, 1'b0, 1'b1, 4'hA);
        // carry-rotate reduction
        run("R2 R9 rcl8 by9", 32'hFFFF_FF5A, 2'b00, 8'd9, 2'b10, 1'b1, 1'b0, 4'h0);
        run("R2 R9 rcr16 by17", 32'h0000_8001, 2'b01, 8'd17, 2'b11, 1'b0, 1'b1, 4'h0);
        run("R2 rcl32 by31", 32'h8000_0001, 2'b10, 8'd31, 2'b10, 1'b1, 1'b0, 4'h0);
        run("R2 rcr8 by10", 32'h0000_00C3, 2'b00, 8'd10, 2'b11, 1'b1, 1'b0, 4'h0);
        // plain reduction
        run("R3 R9 rol8 by8", 32'h0000_0081, 2'b00, 8'd8, 2'b00, 1'b0, 1'b0, 4'h0);
        run("R3 R9 ror16 by16", 32'h0000_4000, 2'b01, 8'd16, 2'b01, 1'b1, 1'b1, 4'h0);
        run("R3 rol16 by17", 32'h0000_8001, 2'b01, 8'd17, 2'b00, 1'b0, 1'b0, 4'h0);
        // single-step semantics
        run("R4 R7 rcl8 by1", 32'h0000_0080, 2'b00, 8'd1, 2'b10, 1'b0, 1'b0, 4'h0);
        run("R5 R7 rcr8 by1", 32'h0000_0001, 2'b00, 8'd1, 2'b11, 1'b1, 1'b0, 4'h0);
        run("R6 R7 rol32 by1", 32'h4000_0000, 2'b10, 8'd1, 2'b00, 1'b1, 1'b0, 4'h0);
        run("R6 R7 ror32 by1", 32'h0000_0001, 2'b10, 8'd1, 2'b01, 1'b0, 1'b0, 4'h0);
        // status passthrough and size codes
        run("R11 stat", 32'hCAFE_F00D, 2'b01, 8'd5, 2'b01, 1'b0, 1'b0, 4'hF);
        run("R12 size3 as word", 32'h8765_4321, 2'b11, 8'd12, 2'b00, 1'b0, 1'b0, 4'h3);
        run("R12 byte upper junk", 32'hFFFF_FF01, 2'b00, 8'd3, 2'b11, 1'b1, 1'b0, 4'h0);
        for (int i = 0; i < 600; i++) begin
            logic [1:0] op, sz;
            op = 2'($urandom);
            sz = 2'($urandom);
            case (op)
                2'b10:   tg = "R4 R7 rand";
                2'b11:   tg = "R5 R7 rand";
                default: tg = "R6 R7 rand";
            endcase
            run(tg, $urandom, sz, 8'($urandom), op, 1'($urandom), 1'($urandom), 4'($urandom));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule